// File: doc/BRIEF.md
# Parallel EEPROM Byte-Write Sequencer

This block sits on the host side of an asynchronous parallel EEPROM bus made of an active-low chip select, an active-low output enable and an active-low write strobe. A client hands it one address and one data byte through a valid/ready handshake. The block then drives a complete byte-write cycle whose address setup, strobe low time and hold are counted in clock cycles. After the write it waits until the memory finishes its internal programming, and reports the outcome with a one-cycle `done` pulse.

The client picks one of two ways to detect completion, per request. In the first, the block watches the memory's ready/busy input. In the second, it reads the written address again and again. While a write is still running, the memory returns the inverse of the written bit 7. A timeout counter bounds the wait in both cases. When a poll read finally shows the true bit 7, all eight bits are compared with the written byte. A difference raises a mismatch flag.

All timing limits are parameters in clock cycles. The defaults assume a 5 ns clock:

| Parameter | Default | Time |
|---|---|---|
| `T_AS` | 2 | 10 ns |
| `T_WP` | 30 | 150 ns |
| `T_AH` | 20 | 100 ns |
| `T_DB` | 10 | 50 ns |
| `T_ACC` | 60 | 300 ns |
| `T_TO` | 700000 | 3.5 ms |

Top module: `eeprom_wr_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` then stays low until and including the cycle in which `done` is high, and request inputs presented in that span have no effect.
- R2: After acceptance, the block drives `mem_ce_n`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=1 for `T_AS` cycles. It then drives `mem_we_n`=0 for exactly `T_WP` cycles, and then `mem_we_n`=1 for `T_AH` cycles with `mem_ce_n` still 0. `mem_dq_oe` stays 1 and `mem_oe_n` stays 1 through all three phases.
- R3: During the write, `mem_addr` holds the accepted address and `mem_dout` holds the accepted byte without change. During poll reads, `mem_addr` holds the accepted address.
- R4: After the hold phase, the bus idles for `T_DB` cycles: `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1 and `mem_dq_oe` is 0. The `mem_rdy` input is ignored during this window.
- R5: In pin mode (`req_pin`=1 at acceptance), `done` goes high in the cycle after the first clock edge past the idle window at which `mem_rdy` is sampled high.
- R6: In poll mode (`req_pin`=0), each read drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_dq_oe`=0 for `T_ACC` cycles. `mem_din` is sampled at the edge ending the last of those cycles. If `mem_din[7]` equals bit 7 of the written byte, `done` follows in the next cycle. Otherwise one cycle with all strobes high separates this read from the next one.
- R7: When a poll completes, `mismatch` is set if any of the eight sampled bits differs from the written byte, and cleared otherwise. Pin-mode completion leaves `mismatch` at 0.
- R8: Waiting cycles are counted from the start of the idle window. If completion has not been seen when `T_TO` waiting cycles have elapsed, the block reports `done` with `timed_out`=1. `timed_out` and `mismatch` are never both 1.
- R9: `done` is high for exactly one cycle per accepted request. `timed_out` and `mismatch` keep their values from that cycle until the next acceptance, which clears them.
- R10: While `rst_n` is low and after its release, the block is idle: `req_ready`=1, `done`=0, all strobes 1, `mem_dq_oe`=0 and both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW | Byte address to write |
| req_data | input | 8 | Byte to write |
| req_pin | input | 1 | 1: detect completion on ready/busy, 0: by read-back polling |
| done | output | 1 | One-cycle completion report |
| timed_out | output | 1 | Wait limit reached, valid from `done` on |
| mismatch | output | 1 | Final read-back differed from written byte |
| mem_addr | output | AW | Memory address bus |
| mem_dout | output | 8 | Data driven to memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | 8 | Data read from memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_rdy | input | 1 | Ready/busy from memory, high when ready |

## Verification
The embedded assertions check properties that hold on every cycle:
- the write strobe only falls while the chip is selected, the output enable is high and data is driven;
- the strobe stays low for exactly `T_WP` cycles;
- address and data do not move while they are in use;
- the drive enable and the output enable are never both active;
- `req_ready` drops after acceptance, `done` lasts one cycle, and the two flags are never both set.

The bench scenarios are needed for the behaviour that depends on the memory's reaction. A memory model answers with inverted bit 7 while busy and releases its ready/busy output late. Against that model, the scenarios show that the block ignores ready/busy during the idle window, that it repeats reads only while bit 7 disagrees, that a corrupted final read raises `mismatch`, and that an endless busy period ends in a timeout in both modes.

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq #(
  parameter int AW    = 13,
  parameter int T_AS  = 2,
  parameter int T_WP  = 30,
  parameter int T_AH  = 20,
  parameter int T_DB  = 10,
  parameter int T_ACC = 60,
  parameter int T_TO  = 700000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          req_pin,
  output logic          done,
  output logic          timed_out,
  output logic          mismatch,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_dout,
  output logic          mem_dq_oe,
  input  logic [7:0]    mem_din,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  input  logic          mem_rdy
);
  localparam int M1 = (T_AS > T_WP) ? T_AS : T_WP;
  localparam int M2 = (T_AH > T_DB) ? T_AH : T_DB;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MX = (M3 > T_ACC) ? M3 : T_ACC;
  localparam int CW = $clog2(MX + 1);
  localparam int TW = $clog2(T_TO + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SET, S_WEL, S_HLD, S_QUIET, S_PIN, S_RD, S_SEP, S_RSP
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt, lim;
  logic [TW-1:0] tcnt;
  logic [AW-1:0] a_q;
  logic [7:0]    d_q;
  logic          pin_q;

  always_comb begin
    case (st)
      S_SET:   lim = CW'(T_AS - 1);
      S_WEL:   lim = CW'(T_WP - 1);
      S_HLD:   lim = CW'(T_AH - 1);
      S_QUIET: lim = CW'(T_DB - 1);
      S_RD:    lim = CW'(T_ACC - 1);
      default: lim = '0;
    endcase
  end

  wire last    = (cnt == lim);
  wire tout    = (tcnt == TW'(T_TO - 1));
  wire waiting = (st == S_QUIET) || (st == S_PIN) || (st == S_RD) || (st == S_SEP);
  wire wr_ph   = (st == S_SET) || (st == S_WEL) || (st == S_HLD);
  wire bit7_ok = (mem_din[7] == d_q[7]);

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_RSP);
  assign mem_addr  = a_q;
  assign mem_dout  = d_q;
  assign mem_dq_oe = wr_ph;
  assign mem_ce_n  = !(wr_ph || st == S_RD);
  assign mem_oe_n  = (st != S_RD);
  assign mem_we_n  = (st != S_WEL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; tcnt <= '0;
      a_q <= '0; d_q <= '0; pin_q <= 1'b0;
      timed_out <= 1'b0; mismatch <= 1'b0;
    end else begin
      cnt <= last ? '0 : cnt + 1'b1;
      if (st == S_IDLE) tcnt <= '0;
      else if (waiting) tcnt <= tcnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (req_valid) begin
            a_q <= req_addr; d_q <= req_data; pin_q <= req_pin;
            timed_out <= 1'b0; mismatch <= 1'b0;
            st <= S_SET;
          end
        end
        S_SET: if (last) st <= S_WEL;
        S_WEL: if (last) st <= S_HLD;
        S_HLD: if (last) st <= S_QUIET;
        S_QUIET:
          if (tout) begin st <= S_RSP; timed_out <= 1'b1; end
          else if (last) st <= pin_q ? S_PIN : S_RD;
        S_PIN:
          if (mem_rdy) st <= S_RSP;
          else if (tout) begin st <= S_RSP; timed_out <= 1'b1; end
        S_RD:
          if (last && bit7_ok) begin st <= S_RSP; mismatch <= (mem_din != d_q); end
          else if (tout) begin st <= S_RSP; timed_out <= 1'b1; end
          else if (last) st <= S_SEP;
        S_SEP:
          if (tout) begin st <= S_RSP; timed_out <= 1'b1; end
          else st <= S_RD;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] wl_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) wl_cnt <= '0;
    else wl_cnt <= mem_we_n ? '0 : wl_cnt + 1'b1;
  end

  // R2
  we_context_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));
  // R2
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && !$past(mem_we_n)) |-> (wl_cnt == CW'(T_WP)));
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dout));
  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  // R1
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(timed_out && mismatch));
endmodule

// File: tb/eeprom_wr_seq_bench.sv
module eeprom_wr_seq_bench;
  localparam int AW = 13, AS = 2, WP = 4, AH = 3, DB = 3, ACC = 3, TO = 400;
  localparam int W3 = AS + WP + AH, W = W3 + DB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_pin = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic req_ready, done, timed_out, mismatch, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_dout;
  logic [7:0] din_q = 8'h00;
  logic rdy_q = 1'b1;

  always #2.5 clk = ~clk;

  eeprom_wr_seq #(.AW(AW), .T_AS(AS), .T_WP(WP), .T_AH(AH), .T_DB(DB),
                  .T_ACC(ACC), .T_TO(TO)) u_eeprom_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_pin(req_pin), .done(done),
    .timed_out(timed_out), .mismatch(mismatch), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dq_oe(mem_dq_oe), .mem_din(din_q),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_rdy(rdy_q));

  int n_cmp = 0, n_bad = 0, cyc = 0;

  // Memory model: updated on the falling edge only
  logic [7:0] mem [0:(1<<AW)-1];
  int ee_busy = 0, ee_age = 0, ee_blen = 10;
  logic [7:0] ee_corrupt = 8'h00, cur_corrupt = 8'h00, wd = 8'h00;
  logic [AW-1:0] wa = '0;
  logic prev_we = 1'b1;
  initial for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hFF;

  always @(negedge clk) begin
    if (prev_we == 1'b0 && mem_we_n == 1'b1 && mem_ce_n == 1'b0) begin
      wa = mem_addr; wd = mem_dout; ee_busy = ee_blen + 2; ee_age = 0;
      cur_corrupt = ee_corrupt;
    end else if (ee_busy > 0) begin
      ee_busy--; ee_age++;
      if (ee_busy == 0) mem[wa] = wd;
    end
    prev_we = mem_we_n;
    rdy_q <= !(ee_busy > 0 && ee_age >= 2);
    if (!mem_ce_n && !mem_oe_n) begin
      if (ee_busy > 0 && mem_addr == wa) din_q <= {~wd[7], 7'h15};
      else din_q <= mem[mem_addr] ^ ((mem_addr == wa) ? cur_corrupt : 8'h00);
    end else din_q <= 8'h00;
  end

  // Reference model: advanced on the rising edge
  int m_stage = 0, m_n = 0, m_tc = 0;
  logic [AW-1:0] m_a = '0;
  logic [7:0] m_d = '0;
  logic m_pin = 1'b0, m_tof = 1'b0, m_mis = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_stage = 0; m_n = 0; m_tc = 0; m_tof = 0; m_mis = 0; m_a = '0; m_d = '0;
    end else begin
      case (m_stage)
        0: if (req_valid) begin
             m_a = req_addr; m_d = req_data; m_pin = req_pin;
             m_tof = 0; m_mis = 0; m_tc = 0; m_n = 0; m_stage = 1;
           end
        1: if (m_n >= W3) begin
             if (m_tc == TO - 1) begin m_stage = 5; m_tof = 1; end
             else begin
               m_tc++;
               if (m_n == W - 1) begin m_stage = m_pin ? 2 : 3; m_n = 0; end
               else m_n++;
             end
           end else m_n++;
        2: if (rdy_q) m_stage = 5;
           else if (m_tc == TO - 1) begin m_stage = 5; m_tof = 1; end
           else m_tc++;
        3: if (m_n == ACC - 1 && din_q[7] == m_d[7]) begin
             m_stage = 5; m_mis = (din_q != m_d);
           end else if (m_tc == TO - 1) begin m_stage = 5; m_tof = 1; end
           else begin
             m_tc++;
             if (m_n == ACC - 1) m_stage = 4; else m_n++;
           end
        4: if (m_tc == TO - 1) begin m_stage = 5; m_tof = 1; end
           else begin m_tc++; m_stage = 3; m_n = 0; end
        default: m_stage = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic e_ce, e_oe, e_we, e_oe_d;
      string st_tag;
      e_ce = !((m_stage == 1 && m_n < W3) || m_stage == 3);
      e_oe = (m_stage != 3);
      e_we = !(m_stage == 1 && m_n >= AS && m_n < AS + WP);
      e_oe_d = (m_stage == 1 && m_n < W3);
      st_tag = (m_stage == 3) ? "R6" : ((m_stage == 1 && m_n >= W3) ? "R4" : "R2");
      chk("R1", "req_ready", req_ready, m_stage == 0);
      chk("R9", "done", done, m_stage == 5);
      chk(st_tag, "strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe},
          {e_ce, e_oe, e_we, e_oe_d});
      if (!e_ce) chk("R3", "mem_addr", mem_addr, m_a);
      if (e_oe_d) chk("R3", "mem_dout", mem_dout, m_d);
      chk("R8", "timed_out", timed_out, m_tof);
      chk("R7", "mismatch", mismatch, m_mis);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic pin,
                    input int blen, input logic [7:0] corrupt, input int hold,
                    input logic exp_to, input logic exp_mis, input string tag);
    int lat;
    while (ee_busy > 0) @(negedge clk);
    ee_blen = blen; ee_corrupt = corrupt;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_pin = pin;
    @(negedge clk);
    lat = 1;
    for (int k = 0; k < hold; k++) begin
      req_data = ~d; req_addr = ~a; req_pin = ~pin;
      @(negedge clk); lat++;
    end
    req_valid = 1'b0;
    while (!done && lat < 5000) begin @(negedge clk); lat++; end
    chk(tag, "done seen", done, 1);
    chk(exp_to ? "R8" : tag, "timed_out at done", timed_out, exp_to);
    chk(exp_mis ? "R7" : tag, "mismatch at done", mismatch, exp_mis);
    if (!exp_to) chk("R4", "done after idle window", (lat > W) ? 1 : 0, 1);
    @(negedge clk);
    chk("R9", "flags held after done", {timed_out, mismatch}, {exp_to, exp_mis});
    chk("R9", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset outputs",
        {req_ready, done, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, timed_out, mismatch},
        8'b10111000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "idle after reset", {req_ready, done, mem_dq_oe}, 3'b100);
    wr(13'h0123, 8'hA5, 1'b0, 60, 8'h00, 0, 1'b0, 1'b0, "R6");
    wr(13'h1FFF, 8'h3C, 1'b0, 40, 8'h00, 0, 1'b0, 1'b0, "R6");
    wr(13'h0000, 8'hFF, 1'b1, 50, 8'h00, 0, 1'b0, 1'b0, "R5");
    wr(13'h0AAA, 8'h81, 1'b0, 30, 8'h10, 0, 1'b0, 1'b1, "R7");
    wr(13'h0555, 8'h7E, 1'b0, 1, 8'h00, 0, 1'b0, 1'b0, "R6");
    wr(13'h0042, 8'h5A, 1'b0, 2000, 8'h00, 0, 1'b1, 1'b0, "R8");
    wr(13'h0043, 8'hC3, 1'b1, 2000, 8'h00, 0, 1'b1, 1'b0, "R8");
    wr(13'h1234, 8'h96, 1'b0, 25, 8'h00, 8, 1'b0, 1'b0, "R1");
    wr(13'h1235, 8'h18, 1'b1, 1, 8'h00, 0, 1'b0, 1'b0, "R5");
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule